// File: doc/BRIEF.md
# Dual-Channel DAC Parallel Write Sequencer

This block is a synchronous host-side controller that loads 12-bit codes into a dual-channel, parallel-loaded converter. The converter has one 12-bit data bus, an active-low select for each channel and one active-low write strobe shared by both channels. A request carries a code and a two-bit channel mask. The sequencer puts the code on the bus, pulls the selected chip selects low and then pulses the strobe. It stretches each phase to a minimum number of clock cycles, so that the converter's setup, pulse-width and hold limits are met at the system clock.

Each phase length is derived at elaboration from a nanosecond minimum and the clock period by ceiling division. The defaults are 80 ns setup, 80 ns strobe width and 25 ns data hold at a 10 ns clock, giving 8, 8 and 3 cycles. The converter latches on the rising edge of the combined select/strobe low window. Selects and strobe therefore release on the same clock edge, and the bus stays unchanged until the hold phase has run out. A behavioural model of the two channel latches is provided for benches. It captures a code when the window in which a select and the strobe are both low comes to an end.

Top module: `dacwr_seq`

## Requirements
- R1: While and directly after reset, both chip selects and the strobe are high, req_ready is high and the bus is zero. The latch model holds zero on both channels.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high and the mask is not 00. req_ready is low from the next cycle until the hold phase has elapsed, and is then high again.
- R3: Mask bit 0 selects channel A and mask bit 1 selects channel B, so 11 selects both. During a transfer, exactly the selected chip selects are low and an unselected select stays high.
- R4: The selected chip selects are low and the bus carries the requested code for SETUP_CYC = ceil(max(select setup, data setup) / period) cycles before the strobe falls. With the defaults this is 8.
- R5: The strobe is low for exactly PULSE_CYC = ceil(strobe width / period) cycles, 8 by default. The bus does not change while any select or the strobe is low.
- R6: Selects and strobe rise on the same clock edge. After that, the bus holds the code and req_ready stays low for HOLD_CYC = ceil(data hold / period) cycles, 3 by default.
- R7: When idle, the controls are high and the bus keeps the last written code. A request with mask 00 is ignored: req_ready stays high, and the bus and controls do not change.
- R8: In the latch model, a channel register loads the bus value when the window in which its select and the strobe are both low ends. The end can be the strobe rising or the select rising. The other channel is unchanged.
- R9: In the latch model, no register changes while the strobe stays high. No register changes while both selects stay high.
- R10: Codes are 12-bit and bit 0 is the least significant. 0x800 is the mid-scale code, 0xFFF is full scale, and 0x000 and 0x001 differ only in bit 0. Every code reaches the addressed latch unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_code | input | 12 | Code to load |
| req_mask | input | 2 | Channel mask: bit 0 channel A, bit 1 channel B |
| dac_data | output | 12 | Parallel data bus to the converter |
| dac_cs_a_n | output | 1 | Channel A chip select, active low |
| dac_cs_b_n | output | 1 | Channel B chip select, active low |
| dac_wr_n | output | 1 | Shared write strobe, active low |

## Verification
A wrong phase state or counter value shows up at the ports within one transfer. The strobe or a select moves a cycle early or late, or req_ready returns before the hold phase is over. A wrong stored mask or code shows up as a wrong select pattern, or as a wrong bus value, from the first cycle after acceptance. The latch model then holds a wrong value one cycle after the selects rise. Directed truth-table sequences drive the latch model alone. They separate the two closing edges, and the cases where the strobe or the selects never fall.

// File: rtl/dacwr_pkg.sv
package dacwr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETUP  = 2'd1,
    SEQ_STROBE = 2'd2,
    SEQ_HOLD   = 2'd3
  } seq_state_e;

  localparam int NUM_CH = 2;
  localparam int CH_A   = 0;
  localparam int CH_B   = 1;

  // cycles needed to cover a minimum in ns, never below one
  function automatic int cycles_for(input int min_ns, input int period_ns);
    int c;
    c = (min_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/dacwr_timer.sv
module dacwr_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/dacwr_ctrl.sv
module dacwr_ctrl
  import dacwr_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 8,
  parameter int HOLD_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_fire,
  input  logic             tmr_expired,
  output seq_state_e       state_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

  seq_state_e state_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (req_fire) begin
          state_d  = SEQ_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_LD;
        end
      end
      SEQ_SETUP: begin
        if (tmr_expired) begin
          state_d  = SEQ_STROBE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LD;
        end
      end
      SEQ_STROBE: begin
        if (tmr_expired) begin
          state_d  = SEQ_HOLD;
          tmr_load = 1'b1;
          tmr_val  = HOLD_LD;
        end
      end
      SEQ_HOLD: begin
        if (tmr_expired) begin
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/dacwr_outreg.sv
module dacwr_outreg
  import dacwr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  seq_state_e          state_d,
  input  logic                capture,
  input  logic [DATA_W-1:0]   code_in,
  input  logic [NUM_CH-1:0]   mask_in,
  output logic [DATA_W-1:0]   bus_q,
  output logic [NUM_CH-1:0]   cs_n_q,
  output logic                wr_n_q,
  output logic                ready_q
);

  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] mask_d;
  logic              sel_phase_d;

  // code and mask are only taken when a transfer is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q  <= '0;
      mask_q <= '0;
    end else if (capture) begin
      bus_q  <= code_in;
      mask_q <= mask_in;
    end
  end

  assign mask_d      = capture ? mask_in : mask_q;
  assign sel_phase_d = (state_d == SEQ_SETUP) || (state_d == SEQ_STROBE);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cs
    logic cs_n_d;
    assign cs_n_d = ~(sel_phase_d & mask_d[ch]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cs_n_q[ch] <= 1'b1;
      end else begin
        cs_n_q[ch] <= cs_n_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_n_q  <= 1'b1;
      ready_q <= 1'b1;
    end else begin
      wr_n_q  <= (state_d != SEQ_STROBE);
      ready_q <= (state_d == SEQ_IDLE);
    end
  end

endmodule

// File: rtl/dacwr_latch_model.sv
module dacwr_latch_model #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus,
  input  logic              cs_a_n,
  input  logic              cs_b_n,
  input  logic              wr_n,
  output logic [DATA_W-1:0] ch_a,
  output logic [DATA_W-1:0] ch_b
);

  logic [DATA_W-1:0] bus_prev;
  logic              cs_a_prev;
  logic              cs_b_prev;
  logic              wr_prev;
  logic              close_a;
  logic              close_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_prev  <= '0;
      cs_a_prev <= 1'b1;
      cs_b_prev <= 1'b1;
      wr_prev   <= 1'b1;
    end else begin
      bus_prev  <= bus;
      cs_a_prev <= cs_a_n;
      cs_b_prev <= cs_b_n;
      wr_prev   <= wr_n;
    end
  end

  // a combined low window ending = rising edge of select OR strobe
  assign close_a = !cs_a_prev && !wr_prev && (cs_a_n || wr_n);
  assign close_b = !cs_b_prev && !wr_prev && (cs_b_n || wr_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_a <= '0;
    end else if (close_a) begin
      ch_a <= bus_prev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_b <= '0;
    end else if (close_b) begin
      ch_b <= bus_prev;
    end
  end

endmodule

// File: rtl/dacwr_seq.sv
module dacwr_seq
  import dacwr_pkg::*;
#(
  parameter int DATA_W          = 12,
  parameter int CLK_PERIOD_NS   = 10,
  parameter int T_DATA_SETUP_NS = 80,
  parameter int T_CS_SETUP_NS   = 80,
  parameter int T_PULSE_NS      = 80,
  parameter int T_DATA_HOLD_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_code,
  input  logic [1:0]        req_mask,
  output logic [DATA_W-1:0] dac_data,
  output logic              dac_cs_a_n,
  output logic              dac_cs_b_n,
  output logic              dac_wr_n
);

  localparam int SETUP_NS  = (T_CS_SETUP_NS > T_DATA_SETUP_NS) ? T_CS_SETUP_NS : T_DATA_SETUP_NS;
  localparam int SETUP_CYC = cycles_for(SETUP_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = cycles_for(T_PULSE_NS, CLK_PERIOD_NS);
  localparam int HOLD_CYC  = cycles_for(T_DATA_HOLD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = (SETUP_CYC > PULSE_CYC)
                             ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                             : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  seq_state_e        state_d;
  logic              req_fire;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic [NUM_CH-1:0] cs_n;

  assign req_fire = req_valid && req_ready && (req_mask != 2'b00);

  dacwr_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  dacwr_ctrl #(
    .CNT_W     (CNT_W),
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_fire    (req_fire),
    .tmr_expired (tmr_expired),
    .state_d     (state_d),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val)
  );

  dacwr_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_d (state_d),
    .capture (req_fire),
    .code_in (req_code),
    .mask_in (req_mask),
    .bus_q   (dac_data),
    .cs_n_q  (cs_n),
    .wr_n_q  (dac_wr_n),
    .ready_q (req_ready)
  );

  assign dac_cs_a_n = cs_n[CH_A];
  assign dac_cs_b_n = cs_n[CH_B];

endmodule

// File: rtl/dacwr_seq_chk.sv
module dacwr_seq_chk #(
  parameter int DATA_W    = 12,
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 8,
  parameter int HOLD_CYC  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mask,
  input logic [DATA_W-1:0] dac_data,
  input logic              dac_cs_a_n,
  input logic              dac_cs_b_n,
  input logic              dac_wr_n
);

  logic [15:0] setup_run;
  logic [15:0] low_run;
  logic [15:0] hold_run;
  logic        any_cs;

  assign any_cs = !dac_cs_a_n || !dac_cs_b_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_run <= '0;
      low_run   <= '0;
      hold_run  <= '0;
    end else begin
      setup_run <= (any_cs && dac_wr_n) ? ((setup_run == 16'hFFFF) ? setup_run : setup_run + 1'b1) : '0;
      low_run   <= (!dac_wr_n) ? ((low_run == 16'hFFFF) ? low_run : low_run + 1'b1) : '0;
      hold_run  <= (!any_cs && !req_ready) ? ((hold_run == 16'hFFFF) ? hold_run : hold_run + 1'b1) : '0;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (dac_cs_a_n && dac_cs_b_n && dac_wr_n));

  assert_mask_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask != 2'b00) |=>
      ((dac_cs_a_n == !$past(req_mask[0])) && (dac_cs_b_n == !$past(req_mask[1]))));

  assert_strobe_has_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_wr_n |-> any_cs);

  assert_setup_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dac_wr_n) |-> (setup_run == 16'(SETUP_CYC)));

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (low_run == 16'(PULSE_CYC)));

  assert_bus_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (any_cs || !dac_wr_n) |=> $stable(dac_data));

  assert_joint_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_wr_n) |-> (dac_cs_a_n && dac_cs_b_n));

  assert_hold_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> (hold_run == 16'(HOLD_CYC)));

  assert_zero_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_mask == 2'b00) |=> (req_ready && $stable(dac_data)));

endmodule

bind dacwr_seq dacwr_seq_chk #(
  .DATA_W    (DATA_W),
  .SETUP_CYC (SETUP_CYC),
  .PULSE_CYC (PULSE_CYC),
  .HOLD_CYC  (HOLD_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_mask   (req_mask),
  .dac_data   (dac_data),
  .dac_cs_a_n (dac_cs_a_n),
  .dac_cs_b_n (dac_cs_b_n),
  .dac_wr_n   (dac_wr_n)
);

// File: tb/dacwr_seq_tb.sv
module dacwr_seq_tb;

  localparam int DW        = 12;
  localparam int PERIOD    = 10;
  localparam int EXP_SETUP = (80 + PERIOD - 1) / PERIOD;
  localparam int EXP_PULSE = (80 + PERIOD - 1) / PERIOD;
  localparam int EXP_HOLD  = (25 + PERIOD - 1) / PERIOD;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [DW-1:0] req_code;
  logic [1:0]    req_mask;
  logic [DW-1:0] dac_data;
  logic          dac_cs_a_n;
  logic          dac_cs_b_n;
  logic          dac_wr_n;
  logic [DW-1:0] mdl_a;
  logic [DW-1:0] mdl_b;

  logic [DW-1:0] tt_bus;
  logic          tt_csa;
  logic          tt_csb;
  logic          tt_wr;
  logic [DW-1:0] tt_a;
  logic [DW-1:0] tt_b;

  int checks;
  int errors;
  logic [DW-1:0] exp_a;
  logic [DW-1:0] exp_b;

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  dacwr_seq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_code   (req_code),
    .req_mask   (req_mask),
    .dac_data   (dac_data),
    .dac_cs_a_n (dac_cs_a_n),
    .dac_cs_b_n (dac_cs_b_n),
    .dac_wr_n   (dac_wr_n)
  );

  dacwr_latch_model #(.DATA_W(DW)) u_model (
    .clk (clk), .rst_n (rst_n), .bus (dac_data),
    .cs_a_n (dac_cs_a_n), .cs_b_n (dac_cs_b_n), .wr_n (dac_wr_n),
    .ch_a (mdl_a), .ch_b (mdl_b)
  );

  dacwr_latch_model #(.DATA_W(DW)) u_ref_tt (
    .clk (clk), .rst_n (rst_n), .bus (tt_bus),
    .cs_a_n (tt_csa), .cs_b_n (tt_csb), .wr_n (tt_wr),
    .ch_a (tt_a), .ch_b (tt_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] sel_of(input logic csa_n, input logic csb_n);
    return {~csb_n, ~csa_n};
  endfunction

  task automatic do_write(input logic [DW-1:0] code, input logic [1:0] mask);
    int s = 0;
    int p = 0;
    int h = 0;
    int guard = 0;
    bit bad_cs = 0;
    bit bad_bus = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_code  = code;
    req_mask  = mask;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 ready low after accept", 32'(req_ready), 32'd0);
    while (!req_ready && guard < 1000) begin
      guard++;
      if (!dac_wr_n) p++;
      else if (!dac_cs_a_n || !dac_cs_b_n) s++;
      else h++;
      if ((s > 0 || p > 0) && h == 0 && sel_of(dac_cs_a_n, dac_cs_b_n) != mask) bad_cs = 1;
      if (dac_data !== code) bad_bus = 1;
      @(negedge clk);
    end
    chk("R3 select pattern matches mask", 32'(bad_cs), 32'd0);
    chk("R4 setup cycles", 32'(s), 32'(EXP_SETUP));
    chk("R5 strobe low cycles", 32'(p), 32'(EXP_PULSE));
    chk("R5 bus stable through transfer", 32'(bad_bus), 32'd0);
    chk("R6 hold cycles", 32'(h), 32'(EXP_HOLD));
    if (mask[0]) exp_a = code;
    if (mask[1]) exp_b = code;
    @(negedge clk);
    chk("R7 idle controls high", {29'd0, dac_cs_a_n, dac_cs_b_n, dac_wr_n}, 32'h7);
    chk("R7 idle bus keeps code", 32'(dac_data), 32'(code));
    chk("R8 channel A latch", 32'(mdl_a), 32'(exp_a));
    chk("R8 channel B latch", 32'(mdl_b), 32'(exp_b));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    exp_a     = '0;
    exp_b     = '0;
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_code  = '0;
    req_mask  = 2'b00;
    tt_bus    = '0;
    tt_csa    = 1'b1;
    tt_csb    = 1'b1;
    tt_wr     = 1'b1;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    chk("R1 controls in reset", {28'd0, dac_cs_a_n, dac_cs_b_n, dac_wr_n, req_ready}, 32'hF);
    chk("R1 bus in reset", 32'(dac_data), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 controls after reset", {28'd0, dac_cs_a_n, dac_cs_b_n, dac_wr_n, req_ready}, 32'hF);
    chk("R1 model zero", {8'd0, mdl_a, mdl_b}, 32'd0);

    // directed corners
    do_write(12'hFFF, 2'b11);   // R10 full scale both channels
    do_write(12'h000, 2'b01);   // R10 zero, A only
    do_write(12'h001, 2'b10);   // R10 bit 0 is LSB, B only
    chk("R10 lsb on channel B", 32'(mdl_b[0]), 32'd1);
    chk("R10 channel A stays zero", 32'(mdl_a), 32'd0);
    do_write(12'h800, 2'b11);   // R10 mid-scale
    chk("R10 midscale msb only", 32'(mdl_a), 32'h800);

    // R7 mask 00 is ignored
    @(negedge clk);
    req_valid = 1'b1;
    req_code  = 12'h3A5;
    req_mask  = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7 zero mask keeps ready", 32'(req_ready), 32'd1);
    chk("R7 zero mask controls idle", {29'd0, dac_cs_a_n, dac_cs_b_n, dac_wr_n}, 32'h7);
    chk("R7 zero mask bus unchanged", 32'(dac_data), 32'h800);
    repeat (3) @(negedge clk);
    chk("R7 zero mask model unchanged", {8'd0, mdl_a, mdl_b}, {8'd0, 12'h800, 12'h800});

    // random traffic
    for (int i = 0; i < 40; i++) begin
      logic [DW-1:0] c;
      logic [1:0]    m;
      c = DW'($urandom);
      m = 2'($urandom_range(1, 3));
      do_write(c, m);
    end

    // latch model truth table, driven directly
    @(negedge clk);
    tt_bus = 12'h5A5; tt_csa = 1'b0; tt_wr = 1'b0;
    @(negedge clk); tt_wr = 1'b1;
    @(negedge clk); tt_csa = 1'b1;
    @(negedge clk);
    chk("R8 strobe rise loads A", 32'(tt_a), 32'h5A5);
    chk("R8 B untouched", 32'(tt_b), 32'h000);
    tt_bus = 12'h3C3; tt_csb = 1'b0; tt_wr = 1'b0;
    @(negedge clk); tt_csb = 1'b1;
    @(negedge clk); tt_wr = 1'b1;
    @(negedge clk);
    chk("R8 select rise loads B", 32'(tt_b), 32'h3C3);
    chk("R8 A untouched", 32'(tt_a), 32'h5A5);
    tt_bus = 12'hFFF; tt_wr = 1'b0;
    @(negedge clk); tt_wr = 1'b1;
    @(negedge clk);
    chk("R9 strobe with selects high", {8'd0, tt_a, tt_b}, {8'd0, 12'h5A5, 12'h3C3});
    tt_csa = 1'b0; tt_csb = 1'b0;
    @(negedge clk); tt_csa = 1'b1; tt_csb = 1'b1;
    @(negedge clk);
    chk("R9 selects with strobe high", {8'd0, tt_a, tt_b}, {8'd0, 12'h5A5, 12'h3C3});
    tt_bus = 12'h800; tt_csa = 1'b0; tt_csb = 1'b0; tt_wr = 1'b0;
    @(negedge clk); tt_wr = 1'b1;
    @(negedge clk); tt_csa = 1'b1; tt_csb = 1'b1;
    @(negedge clk);
    chk("R8 joint load both", {8'd0, tt_a, tt_b}, {8'd0, 12'h800, 12'h800});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule